// File: doc/BRIEF.md
# Page-Split DMA Descriptor Chain Builder

This block turns a single transfer request (start address, byte length and direction) into a chain of DMA command descriptors. It writes the chain, one entry per clock, into a small descriptor memory that sits outside the block. Each entry carries an opcode, a byte count, an address and three condition fields. The chain is cut at page boundaries so that no data descriptor spans two pages. It always ends with a stop entry. Addresses pass through unchanged; no translation is applied.

A requester pulses a start strobe while the block is idle. The block then plans the chain. If the chain would not fit in the memory, it reports overflow and writes nothing. Otherwise it emits the entries and finishes with a one-cycle done pulse that carries the total entry count. The DMA engine that later runs the chain is not part of this block.

Top module: `dma_chain_builder`

## Requirements
- R1: After reset, busy, done, overflow and the write strobe are all low, and descCount is zero.
- R2: A start pulse is taken only while busy is low. Busy rises in the next cycle and stays high through the done cycle. A start pulse while busy has no effect on the chain being built.
- R3: When the start address has a nonzero page offset and the length exceeds the bytes left in that page, entry 0 carries exactly PAGE minus offset bytes at the start address.
- R4: When the start address is unaligned and the length fits inside the rest of that page, the chain is one final data entry holding the whole length, then the stop entry.
- R5: While the remaining length is strictly greater than one page, full-page entries are emitted, and each entry's address is the previous address plus the previous count.
- R6: The last data entry carries the remaining length, which is at most one page, including exactly one page when the length is a page multiple.
- R7: Opcode field (4 bits): write-direction more = 0, write-direction last = 1, read-direction more = 2, read-direction last = 3. Only the last data entry uses a "last" code.
- R8: The stop entry has opcode 7, count 0 and address 0, and follows the last data entry directly.
- R9: The condition output wrCond (interrupt in bits 5:4, wait in 3:2, branch in 1:0) is all zeros ("never") on every entry.
- R10: Entries are written at consecutive indices from 0, one per cycle, with no gap cycles between them.
- R11: done is high for exactly one cycle, in the cycle after the stop entry is written, and descCount then equals the number of entries including the stop entry.
- R12: A request needing more than DEPTH entries (stop included) raises overflow together with done, writes no entry, and gives descCount 0. A request needing exactly DEPTH entries completes normally.
- R13: A zero-length request produces one final data entry of count 0 at the start address, then the stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | One-cycle request strobe, taken only when idle |
| reqAddr | input | ADDR_W | Transfer start address |
| reqLen | input | LEN_W | Transfer length in bytes |
| reqIsRead | input | 1 | 1 = read (device to memory), 0 = write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | High with done when the chain did not fit |
| descCount | output | CNT_W | Entry count, valid with done |
| wrEn | output | 1 | Descriptor write strobe |
| wrIdx | output | IDX_W | Descriptor index being written |
| wrOp | output | 4 | Descriptor opcode |
| wrCount | output | LEN_W | Descriptor byte count |
| wrAddr | output | ADDR_W | Descriptor address |
| wrCond | output | 6 | Interrupt, wait and branch condition fields |

## Verification
The assertions assume that startReq arrives as a pulse and that reqAddr, reqLen and reqIsRead are valid in the cycle the pulse is taken. They also assume LEN_W is wide enough that a page fits in a count. The bench drives each request for a single cycle at the falling clock edge. It issues a second start only while busy is high, to check that the pulse is ignored. It keeps lengths well inside LEN_W, so the planned entry count never wraps.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [3:0] {
    OP_OUT_MORE = 4'd0,
    OP_OUT_LAST = 4'd1,
    OP_IN_MORE  = 4'd2,
    OP_IN_LAST  = 4'd3,
    OP_STOP     = 4'd7
  } descOp_t;

  localparam logic [1:0] COND_NEVER = 2'd0;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch a new request
    logic plan;       // evaluate first-page split
    logic writeData;  // emit one data entry and advance
    logic writeStop;  // emit the stop entry
    logic finish;     // present the entry count
  } chainStrobes_t;

endpackage

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
  import dma_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          tooMany,
  input  logic          finalData,
  output chainStrobes_t strobes,
  output logic          busy,
  output logic          done,
  output logic          overflow
);

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_EMIT, S_STOP, S_FINISH
  } state_t;

  state_t state, stateNext;
  logic   ovfFlag;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:   if (startReq) stateNext = S_PLAN;
      S_PLAN:   stateNext = tooMany ? S_FINISH : S_EMIT;
      S_EMIT:   if (finalData) stateNext = S_STOP;
      S_STOP:   stateNext = S_FINISH;
      S_FINISH: stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      ovfFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && startReq) ovfFlag <= 1'b0;
      else if (state == S_PLAN)        ovfFlag <= tooMany;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.capture   = (state == S_IDLE) && startReq;
    strobes.plan      = (state == S_PLAN);
    strobes.writeData = (state == S_EMIT);
    strobes.writeStop = (state == S_STOP);
    strobes.finish    = (state == S_FINISH) && !ovfFlag;
  end

  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FINISH);
  assign overflow = (state == S_FINISH) && ovfFlag;

endmodule

// File: rtl/dma_chain_dp.sv
module dma_chain_dp
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int DEPTH      = 20,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  chainStrobes_t     strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqIsRead,
  output logic              tooMany,
  output logic              finalData,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [3:0]        wrOp,
  output logic [LEN_W-1:0]  wrCount,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [5:0]        wrCond,
  output logic [CNT_W-1:0]  descCount
);

  localparam int unsigned PAGE = 1 << PAGE_SHIFT;
  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(PAGE);

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remLen;
  logic              isRead;
  logic              firstPend;
  logic [CNT_W-1:0]  idx;

  // page arithmetic on the current position
  logic [PAGE_SHIFT-1:0] pageOff;
  logic [LEN_W-1:0]      pageRest;
  logic                  crossFirst;
  logic [LEN_W-1:0]      afterFirst;
  logic [LEN_W:0]        roundSum;
  logic [LEN_W:0]        dataEntries;
  logic [LEN_W+1:0]      needTotal;

  assign pageOff    = curAddr[PAGE_SHIFT-1:0];
  assign pageRest   = PAGE_LEN - LEN_W'(pageOff);
  assign crossFirst = (pageOff != '0) && (remLen > pageRest);
  assign afterFirst = crossFirst ? (remLen - pageRest) : remLen;
  assign roundSum   = {1'b0, afterFirst} + (LEN_W+1)'(PAGE - 1);
  assign dataEntries = (afterFirst == '0) ? (LEN_W+1)'(1)
                                          : (roundSum >> PAGE_SHIFT);
  assign needTotal  = {1'b0, dataEntries} + (LEN_W+2)'(crossFirst) + (LEN_W+2)'(1);
  assign tooMany    = needTotal > (LEN_W+2)'(DEPTH);

  // size of the entry emitted this cycle
  logic [LEN_W-1:0] stepLen;
  always_comb begin
    if (firstPend)             stepLen = pageRest;
    else if (remLen > PAGE_LEN) stepLen = PAGE_LEN;
    else                       stepLen = remLen;
  end
  assign finalData = !firstPend && (remLen <= PAGE_LEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      remLen    <= '0;
      isRead    <= 1'b0;
      firstPend <= 1'b0;
      idx       <= '0;
    end else begin
      if (strobes.capture) begin
        curAddr   <= reqAddr;
        remLen    <= reqLen;
        isRead    <= reqIsRead;
        firstPend <= 1'b0;
        idx       <= '0;
      end
      if (strobes.plan) firstPend <= crossFirst;
      if (strobes.writeData) begin
        curAddr   <= curAddr + ADDR_W'(stepLen);
        remLen    <= remLen - stepLen;
        firstPend <= 1'b0;
        idx       <= idx + 1'b1;
      end
      if (strobes.writeStop) idx <= idx + 1'b1;
    end
  end

  // write port
  always_comb begin
    wrEn    = strobes.writeData || strobes.writeStop;
    wrIdx   = idx[IDX_W-1:0];
    wrCond  = {COND_NEVER, COND_NEVER, COND_NEVER};
    wrOp    = 4'(OP_STOP);
    wrCount = '0;
    wrAddr  = '0;
    if (strobes.writeData) begin
      if (finalData) wrOp = isRead ? 4'(OP_IN_LAST) : 4'(OP_OUT_LAST);
      else           wrOp = isRead ? 4'(OP_IN_MORE) : 4'(OP_OUT_MORE);
      wrCount = stepLen;
      wrAddr  = curAddr;
    end
  end

  assign descCount = strobes.finish ? idx : '0;

endmodule

// File: rtl/dma_chain_builder.sv
module dma_chain_builder
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int DEPTH      = 20,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqIsRead,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  output logic [CNT_W-1:0]  descCount,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [3:0]        wrOp,
  output logic [LEN_W-1:0]  wrCount,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [5:0]        wrCond
);

  chainStrobes_t strobes;
  logic          tooMany;
  logic          finalData;

  dma_chain_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .tooMany   (tooMany),
    .finalData (finalData),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow)
  );

  dma_chain_dp #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .DEPTH      (DEPTH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqIsRead (reqIsRead),
    .tooMany   (tooMany),
    .finalData (finalData),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrOp      (wrOp),
    .wrCount   (wrCount),
    .wrAddr    (wrAddr),
    .wrCond    (wrCond),
    .descCount (descCount)
  );

endmodule

// File: rtl/dma_chain_builder_chk.sv
module dma_chain_builder_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int DEPTH      = 20,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              overflow,
  input logic [CNT_W-1:0]  descCount,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [3:0]        wrOp,
  input logic [LEN_W-1:0]  wrCount,
  input logic [ADDR_W-1:0] wrAddr
);

  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(1 << PAGE_SHIFT);

  // R11: done follows the stop write by one cycle
  p_stop_then_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp == 4'd7) |=> done);

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: stop entry carries zero count and address
  p_stop_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp == 4'd7) |-> (wrCount == '0 && wrAddr == '0));

  // R6: no data entry exceeds a page
  p_count_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrOp != 4'd7) |-> (wrCount <= PAGE_LEN));

  // R10: back-to-back writes use consecutive indices
  p_idx_seq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> (wrIdx == $past(wrIdx) + 1'b1));

  // R10: indices stay inside the memory
  p_idx_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (32'(wrIdx) < DEPTH));

  // R12: overflow finishes with no write and zero count
  p_no_write_ovf_r12: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (done && descCount == '0 && !$past(wrEn)));

  // R2: writes only happen inside a busy window
  p_write_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> busy);

  // R2: busy drops right after done
  p_busy_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind dma_chain_builder dma_chain_builder_chk #(
  .ADDR_W (ADDR_W), .LEN_W (LEN_W), .PAGE_SHIFT (PAGE_SHIFT), .DEPTH (DEPTH)
) chk_i (
  .clk (clk), .rstN (rstN), .busy (busy), .done (done), .overflow (overflow),
  .descCount (descCount), .wrEn (wrEn), .wrIdx (wrIdx), .wrOp (wrOp),
  .wrCount (wrCount), .wrAddr (wrAddr)
);

// File: tb/dma_chain_builder_tb.sv
module dma_chain_builder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 24;
  localparam int PSH    = 12;
  localparam int DEPTH  = 20;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int PAGE   = 1 << PSH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic reqIsRead = 1'b0;
  logic busy, done, overflow, wrEn;
  logic [CNT_W-1:0]  descCount;
  logic [IDX_W-1:0]  wrIdx;
  logic [3:0]        wrOp;
  logic [LEN_W-1:0]  wrCount;
  logic [ADDR_W-1:0] wrAddr;
  logic [5:0]        wrCond;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chain_builder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_SHIFT(PSH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqIsRead(reqIsRead), .busy(busy), .done(done), .overflow(overflow),
    .descCount(descCount), .wrEn(wrEn), .wrIdx(wrIdx), .wrOp(wrOp),
    .wrCount(wrCount), .wrAddr(wrAddr), .wrCond(wrCond));

  int nChecks = 0;
  int nFails  = 0;
  int cyc = 0;

  // recorded writes
  int  recN = 0;
  int  recOp [64];
  longint recCnt [64];
  longint recAddr [64];
  bit  recCondBad = 0;
  bit  recGap = 0;
  bit  recIdxBad = 0;
  int  stopCyc = -1;
  int  lastWrCyc = -1;

  // expected chain
  int  expN;
  bit  expOvf;
  int  expOp [64];
  longint expCnt [64];
  longint expAddr [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wrEn) begin
      if (32'(wrIdx) != recN) recIdxBad = 1;
      if (recN > 0 && lastWrCyc != cyc - 1) recGap = 1;
      if (wrCond != 6'd0) recCondBad = 1;
      if (recN < 64) begin
        recOp[recN] = int'(wrOp);
        recCnt[recN] = longint'(wrCount);
        recAddr[recN] = longint'(wrAddr);
      end
      if (wrOp == 4'd7) stopCyc = cyc;
      lastWrCyc = cyc;
      recN++;
    end
  end

  // reference chain from the requirements
  task automatic buildExp(input longint a, input longint len, input bit rd);
    longint rest;
    longint off;
    int moreOp;
    int lastOp;
    moreOp = rd ? 2 : 0;
    lastOp = rd ? 3 : 1;
    expN = 0;
    off = a % PAGE;
    if (off != 0) begin
      rest = PAGE - off;
      if (len > rest) begin
        expOp[expN] = moreOp; expCnt[expN] = rest; expAddr[expN] = a; expN++;
        a += rest; len -= rest;
      end
    end
    while (len > PAGE) begin
      if (expN < 60) begin
        expOp[expN] = moreOp; expCnt[expN] = PAGE; expAddr[expN] = a;
      end
      expN++;
      a += PAGE; len -= PAGE;
    end
    if (expN < 62) begin
      expOp[expN] = lastOp; expCnt[expN] = len; expAddr[expN] = a;
      expOp[expN+1] = 7; expCnt[expN+1] = 0; expAddr[expN+1] = 0;
    end
    expN += 2;
    expOvf = (expN > DEPTH);
  endtask

  // run one request; optional second start while busy
  task automatic runReq(input string req, input longint a, input longint len,
                        input bit rd, input bit inject);
    int doneCyc;
    int waitN;
    recN = 0; recCondBad = 0; recGap = 0; recIdxBad = 0; stopCyc = -1;
    buildExp(a, len, rd);
    @(negedge clk);
    reqAddr = ADDR_W'(a); reqLen = LEN_W'(len); reqIsRead = rd; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", longint'(busy), 1);
    if (inject) begin
      @(negedge clk);
      reqAddr = 32'h0000_8000; reqLen = 24'd5; reqIsRead = !rd; startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    waitN = 0;
    while (done !== 1'b1 && waitN < 200) begin
      @(negedge clk);
      waitN++;
    end
    doneCyc = cyc;
    chk(done === 1'b1, req, "done seen", longint'(done), 1);
    chk(busy === 1'b1, "R2", "busy in done cycle", longint'(busy), 1);
    chk(overflow === expOvf, expOvf ? "R12" : req, "overflow", longint'(overflow), longint'(expOvf));
    if (expOvf) begin
      chk(recN == 0, "R12", "writes on overflow", recN, 0);
      chk(descCount == 0, "R12", "descCount on overflow", longint'(descCount), 0);
    end else begin
      chk(32'(descCount) == expN, "R11", "descCount", longint'(descCount), expN);
      chk(recN == expN, req, "entries written", recN, expN);
      chk(doneCyc == stopCyc + 1, "R11", "done after stop", doneCyc, stopCyc + 1);
      chk(!recCondBad, "R9", "condition fields never", longint'(recCondBad), 0);
      chk(!recGap && !recIdxBad, "R10", "consecutive indices", longint'(recGap | recIdxBad), 0);
      for (int i = 0; i < expN && i < recN; i++) begin
        chk(recOp[i] == expOp[i], (i == expN-1) ? "R8" : "R7", $sformatf("%s op[%0d]", req, i), recOp[i], expOp[i]);
        chk(recCnt[i] == expCnt[i], (i == expN-1) ? "R8" : req, $sformatf("count[%0d]", i), recCnt[i], expCnt[i]);
        chk(recAddr[i] == expAddr[i], (i == 0) ? req : "R5", $sformatf("addr[%0d]", i), recAddr[i], expAddr[i]);
      end
    end
    @(negedge clk);
    chk(done === 1'b0, "R11", "done one cycle", longint'(done), 0);
    chk(busy === 1'b0, "R2", "idle after done", longint'(busy), 0);
    chk(recN == (expOvf ? 0 : expN), "R2", "no extra chain", recN, expOvf ? 0 : expN);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy", longint'(busy), 0);
    chk(done === 1'b0, "R1", "done", longint'(done), 0);
    chk(overflow === 1'b0, "R1", "overflow", longint'(overflow), 0);
    chk(wrEn === 1'b0, "R1", "wrEn", longint'(wrEn), 0);
    chk(descCount == 0, "R1", "descCount", longint'(descCount), 0);
  endtask

  task automatic t_aligned_multi();      runReq("R5", 64'h1000, 3*PAGE, 1'b1, 1'b0); endtask
  task automatic t_unaligned_cross();    runReq("R3", 64'h0100, PAGE, 1'b0, 1'b0); endtask
  task automatic t_unaligned_inside();   runReq("R4", 64'h2F00, 200, 1'b1, 1'b0); endtask
  task automatic t_odd_span();           runReq("R6", 64'h0FFF, 10000, 1'b0, 1'b0); endtask
  task automatic t_zero_len();           runReq("R13", 64'h3456, 0, 1'b1, 1'b0); endtask
  task automatic t_exact_fit();          runReq("R12", 64'h10000, 19*PAGE, 1'b0, 1'b0); endtask
  task automatic t_overflow();           runReq("R12", 64'h10000, 20*PAGE, 1'b1, 1'b0); endtask
  task automatic t_busy_ignore();        runReq("R2", 64'h5010, 2*PAGE, 1'b0, 1'b1); endtask
  task automatic t_page_multiple();      runReq("R6", 64'h7000, 2*PAGE, 1'b1, 1'b0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_aligned_multi();
    t_unaligned_cross();
    t_unaligned_inside();
    t_odd_span();
    t_zero_len();
    t_exact_fit();
    t_overflow();
    t_busy_ignore();
    t_page_multiple();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule